// File: doc/BRIEF.md
# Randomized-Origin Rotating Element Selector

This block chooses which unit elements of a 16-element feedback DAC are switched on in each sample of a multi-bit sigma-delta loop. Each sample it takes a level from the quantizer (0 to 16) and a pseudo-random value from an external source. It returns a 16-bit enable vector with exactly that many bits set. The selection rotates through the array so that every element is used equally often, which shapes element mismatch out of the signal band.

Plain rotation repeats its pattern periodically and so produces in-band tones. To break that period, the block tracks an origin. Each time the rotation has used every element once since the origin, the origin jumps forward by a bounded random step. The elements that wrapped past the old origin in that sample are moved forward by the same step. The step is limited so that the moved elements never collide with the other elements selected in that sample. A disable input forces the step to zero, which turns the block into a plain rotating selector for test.

The datapath has three stages. The first rotates the thermometer code by the position of the start pointer relative to the origin. The second shifts the wrapped elements locally. The third rotates the result by the absolute origin, which is the running sum of all steps. The enable vector is registered once per sample clock.

Top module: `rdwa_selector`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge), sel_out is all zeros and the start pointer and the origin are both at element 0. The first nonzero level k therefore selects elements 0..k-1 (bit i of sel_out enables element i).
- R2: One clock edge after a level is presented, the number of ones in sel_out equals that level, with levels above 16 counted as 16.
- R3: When a sample does not complete a turn, it selects k elements that are adjacent modulo 16, starting at the start pointer. The start pointer then advances by k modulo 16.
- R4: A level of 0 gives an all-zero sel_out and leaves the start pointer and the origin unchanged.
- R5: A sample completes a turn when u + k >= 16, where u is the number of elements used since the origin. In that case the last w = u + k - 16 elements of the run (those at and after the origin) are moved forward by s = min(rnd_in, 16 - k). The origin then moves forward by s, and the next start pointer is the new origin plus w. When no turn completes, the origin does not move.
- R6: With rand_off high, s is 0. The block then behaves as plain rotation: the start pointer always advances by k modulo 16 and the origin never moves.
- R7: A level of 16 sets all bits of sel_out and counts as a completed turn with s = 0.
- R8: Level values 17 to 31 are treated exactly as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lvl_in | input | 5 | Quantizer level, number of elements to enable |
| rnd_in | input | 4 | Pseudo-random candidate step |
| rand_off | input | 1 | Forces the origin step to zero (plain rotation) |
| sel_out | output | 16 | Registered element enable vector |

## Verification
A wrong start pointer shows in the very next nonzero sample as a run that begins at the wrong element. A wrong origin or a wrong step stays hidden until the next completed turn. At that point the wrapped elements land in the wrong place, and every later pattern is displaced. The bench therefore compares every sample against a model that keeps absolute start and origin positions, so a corrupted state is caught within at most one turn of 16 used elements. Directed samples cover zero levels, full-scale and over-range levels, and a random step larger than the free room.

// File: rtl/rdwa_pkg.sv
// Package: shared constants for the randomized-origin element selector.
// Assumes the element count is a power of two so pointers wrap naturally.
package rdwa_pkg;
    localparam int DEF_ELEMS = 16;
endpackage

// File: rtl/rdwa_rotl.sv
// Module: logarithmic left rotator.
// Rotates din left (toward higher bit index) by amt positions, modulo WIDTH.
// Assumes WIDTH == 2**SHW.
module rdwa_rotl #(
    parameter int WIDTH = 16,
    parameter int SHW   = 4
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SHW-1:0]   amt,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [0:SHW];

    assign stg[0] = din;

    // One stage per amount bit, each rotating by a power of two.
    for (genvar g = 0; g < SHW; g++) begin : g_stage
        localparam int D = 1 << g;
        assign stg[g+1] = amt[g] ? {stg[g][WIDTH-1-D:0], stg[g][WIDTH-1 -: D]}
                                 : stg[g];
    end

    assign dout = stg[SHW];
endmodule

// File: rtl/rdwa_local_shift.sv
// Module: local element shifter.
// Moves the lowest wrap_cnt positions of an origin-relative code up by sh2
// and leaves the other bits in place. Assumes the caller has bounded sh2 so
// that the moved bits cannot reach any other set bit or run off the top.
module rdwa_local_shift #(
    parameter int NUM_EL = 16,
    parameter int PTR_W  = 4,
    parameter int CNT_W  = 5
) (
    input  logic [NUM_EL-1:0] t1,
    input  logic [CNT_W-1:0]  wrap_cnt,
    input  logic [PTR_W-1:0]  sh2,
    output logic [NUM_EL-1:0] t2
);
    logic [NUM_EL-1:0] low_mask;

    // Mask of the wrapped region: relative positions below wrap_cnt.
    for (genvar i = 0; i < NUM_EL; i++) begin : g_mask
        assign low_mask[i] = (wrap_cnt > CNT_W'(i));
    end

    // Keep unwrapped bits; lift wrapped bits by the random step.
    always_comb begin
        t2 = (t1 & ~low_mask) | ((t1 & low_mask) << sh2);
    end
endmodule

// File: rtl/rdwa_ptr_ctrl.sv
// Module: pointer control for the randomized-origin selector.
// Holds the used-since-origin count and the absolute origin (the running
// sum of random steps). It detects completed turns and derives the bounded
// random step. Assumes k is already clamped to 0..NUM_EL.
module rdwa_ptr_ctrl #(
    parameter int NUM_EL = 16,
    parameter int PTR_W  = 4,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] k,
    input  logic [PTR_W-1:0] rnd,
    input  logic             rand_off,
    output logic [PTR_W-1:0] used_q,
    output logic [PTR_W-1:0] orig_q,
    output logic [CNT_W-1:0] wrap_cnt,
    output logic [PTR_W-1:0] sh2,
    output logic             full
);
    localparam logic [CNT_W:0]   FULL_V = (CNT_W+1)'(NUM_EL);
    localparam logic [CNT_W-1:0] EL_V   = CNT_W'(NUM_EL);

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] room;
    logic [CNT_W-1:0] rnd_ext;
    logic [CNT_W-1:0] lim;

    // Turn detection and the count of elements that wrap past the origin.
    always_comb begin
        sum      = (CNT_W+1)'(used_q) + (CNT_W+1)'(k);
        full     = (sum >= FULL_V);
        wrap_cnt = full ? CNT_W'(sum - FULL_V) : '0;
    end

    // Random step bounded by the room left free by this sample's run.
    always_comb begin
        room    = EL_V - k;
        rnd_ext = CNT_W'(rnd);
        lim     = (rnd_ext > room) ? room : rnd_ext;
        sh2     = (full && !rand_off) ? PTR_W'(lim) : '0;
    end

    // Pointer state update, once per sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
            orig_q <= '0;
        end else if (full) begin
            used_q <= PTR_W'(wrap_cnt);
            orig_q <= orig_q + sh2;
        end else begin
            used_q <= PTR_W'(sum);
        end
    end

    // R5: the origin moves only on a completed turn.
    p_orig_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(full)) |-> (orig_q == $past(orig_q)));

    // R4: a zero level leaves both pointers unchanged.
    p_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(k) == '0) |-> ($stable(used_q) && $stable(orig_q)));

    // R6: with randomization off the origin never moves.
    p_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rand_off)) |-> $stable(orig_q));
endmodule

// File: rtl/rdwa_selector.sv
// Module: randomized-origin rotating element selector (top).
// Builds a thermometer code from the clamped level, rotates it to the start
// pointer relative to the origin, shifts wrapped elements by the random step,
// rotates by the absolute origin and registers the enable vector.
// Assumes one sample per clock and a power-of-two element count.
module rdwa_selector #(
    parameter  int NUM_EL = rdwa_pkg::DEF_ELEMS,
    localparam int PTR_W  = $clog2(NUM_EL),
    localparam int CNT_W  = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  lvl_in,
    input  logic [PTR_W-1:0]  rnd_in,
    input  logic              rand_off,
    output logic [NUM_EL-1:0] sel_out
);
    localparam logic [CNT_W-1:0] EL_V = CNT_W'(NUM_EL);

    logic [CNT_W-1:0]  k;
    logic [NUM_EL-1:0] therm;
    logic [NUM_EL-1:0] t1;
    logic [NUM_EL-1:0] t2;
    logic [NUM_EL-1:0] t3;
    logic [PTR_W-1:0]  used_q;
    logic [PTR_W-1:0]  orig_q;
    logic [CNT_W-1:0]  wrap_cnt;
    logic [PTR_W-1:0]  sh2;
    logic              full;
    logic [NUM_EL-1:0] sel_q;

    // Clamp over-range levels to full scale.
    always_comb begin
        k = (lvl_in > EL_V) ? EL_V : lvl_in;
    end

    // Thermometer code of the clamped level.
    for (genvar i = 0; i < NUM_EL; i++) begin : g_therm
        assign therm[i] = (k > CNT_W'(i));
    end

    rdwa_ptr_ctrl #(.NUM_EL(NUM_EL), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .k        (k),
        .rnd      (rnd_in),
        .rand_off (rand_off),
        .used_q   (used_q),
        .orig_q   (orig_q),
        .wrap_cnt (wrap_cnt),
        .sh2      (sh2),
        .full     (full)
    );

    rdwa_rotl #(.WIDTH(NUM_EL), .SHW(PTR_W)) u_rot_rel (
        .din  (therm),
        .amt  (used_q),
        .dout (t1)
    );

    rdwa_local_shift #(.NUM_EL(NUM_EL), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_lshift (
        .t1       (t1),
        .wrap_cnt (wrap_cnt),
        .sh2      (sh2),
        .t2       (t2)
    );

    rdwa_rotl #(.WIDTH(NUM_EL), .SHW(PTR_W)) u_rot_abs (
        .din  (t2),
        .amt  (orig_q),
        .dout (t3)
    );

    // Output register, one update per sample.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= t3;
    end

    assign sel_out = sel_q;

    // R2: number of enabled elements equals the clamped level.
    p_count_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(sel_q) == int'($past(k))));

    // R7: full scale enables every element.
    p_all_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lvl_in) >= EL_V) |-> (&sel_q));

    // R4: a zero level enables nothing.
    p_zero_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lvl_in) == '0) |-> (sel_q == '0));
endmodule

// File: tb/rdwa_selector_bench.sv
// Bench: directed corners plus seeded random levels, checked against a model
// that keeps absolute start and origin positions.
module rdwa_selector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  lvl_in = '0;
    logic [3:0]  rnd_in = '0;
    logic        rand_off = 1'b0;
    logic [15:0] sel_out;

    int checks = 0;
    int errors = 0;
    int m_start = 0;
    int m_orig = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rdwa_selector u_rdwa_selector (
        .clk(clk), .rst_n(rst_n), .lvl_in(lvl_in), .rnd_in(rnd_in),
        .rand_off(rand_off), .sel_out(sel_out)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model one sample: returns expected enables and advances model state.
    function automatic logic [15:0] model_step(input int lvl, input int rnd, input bit off,
                                               output bit turned);
        int kk, u, w, room, s, pos;
        logic [15:0] e;
        kk = (lvl > 16) ? 16 : lvl;
        u = (m_start - m_orig) & 15;
        turned = (u + kk >= 16);
        w = turned ? u + kk - 16 : 0;
        room = 16 - kk;
        s = (!turned || off) ? 0 : ((rnd > room) ? room : rnd);
        e = '0;
        for (int i = 0; i < kk; i++) begin
            pos = m_start + i;
            if (turned && i >= kk - w) pos += s;
            e[pos & 15] = 1'b1;
        end
        if (turned) begin
            m_orig = (m_orig + s) & 15;
            m_start = (m_orig + w) & 15;
        end else begin
            m_start = (m_start + kk) & 15;
        end
        return e;
    endfunction

    // Drive one sample at a falling edge, compare at the next falling edge.
    task automatic sample(input int lvl, input int rnd, input bit off, input string tag);
        logic [15:0] e;
        bit turned;
        int kk;
        lvl_in = 5'(lvl);
        rnd_in = 4'(rnd);
        rand_off = off;
        e = model_step(lvl, rnd, off, turned);
        @(negedge clk);
        check(sel_out, e, tag);
        kk = (lvl > 16) ? 16 : lvl;
        check(16'($countones(sel_out)), 16'(kk), "R2 count");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        bit off;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(sel_out, 16'h0000, "R1 reset output");
        sample(3, 0, 0, "R1 first run from element 0");
        check(sel_out, 16'h0007, "R1 literal 0x0007");
        sample(0, 9, 0, "R4 zero level");
        sample(2, 0, 0, "R4 pointer unchanged after zero");
        check(sel_out, 16'h0018, "R4 literal 0x0018");
        sample(13, 2, 0, "R5 turn with step 2");
        check(sel_out, 16'hFFEC, "R5 literal 0xFFEC");
        sample(16, 7, 0, "R7 full scale");
        sample(20, 5, 0, "R8 over-range level");
        sample(15, 9, 0, "R5 step clamped to room");
        check(sel_out, 16'hFFFB, "R5 literal 0xFFFB");
        sample(5, 3, 0, "R3 run after turn");
        for (int n = 0; n < 40; n++) sample(int'($urandom_range(0, 9)), 15, 1, "R6 plain rotation");
        for (int n = 0; n < 3000; n++) begin
            off = ($urandom_range(0, 7) == 0);
            sample(int'($urandom_range(0, 20)), int'($urandom_range(0, 15)), off,
                   off ? "R6 random" : "R3/R5 random");
        end
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_start = 0;
        m_orig = 0;
        check(sel_out, 16'h0000, "R1 second reset");
        sample(1, 0, 0, "R1 start at zero after reset");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule